// File: doc/BRIEF.md
# Oxide-Rupture PUF Array Sequencer

This block sequences a one-time-programmable unclonable array. Each cell holds two gate-oxide devices, and exactly one of the two is meant to rupture. Which one ruptures comes from natural variation, and that choice is the cell's secret bit. The analog high-voltage sweep, the current detectors and the sense amplifiers sit outside the block. The sequencer drives them through a digital ramp code, select lines and detect inputs.

A program command works through the columns in ascending order. For each column, every row is driven at once, because each row has its own supply line. The ramp code climbs from zero in unit steps, and the spacing between steps is set by an input. A row stops being driven as soon as either of its devices reports a rupture. At the end of each column, one report carries masks of rows where both devices ruptured (over) and rows where neither did (under). A read command selects one row and senses every column of it together. It returns one response word per command, plus a per-column validity mask. A sticky lock bit, set once after factory programming, refuses every later program command. It can be cleared only by power-up reset.

Top module: `puf_array_ctrl`

## Requirements
- R1: While and right after reset, busy, locked, prog_err, ramp_en, rpt_valid and rsp_valid are 0, and col_sel, row_drive and rd_row_sel are all zero.
- R2: A program command (cmd_op = 1) accepted while idle and unlocked raises busy in the next cycle. It drives col_sel one-hot with ramp_en high, visiting columns 0 to COLS-1 in order. busy falls in the same cycle as the report for the last column.
- R3: At the start of each column the ramp code is 0. Each value is held for exactly step_cycles cycles before it rises by 1, and a step_cycles of 0 counts as 1.
- R4: At the start of each column every row is driven. From the cycle after a blow detect (left or right) is sampled on a row, that row is no longer driven for the rest of the column.
- R5: A column ends as soon as every row has seen a rupture. The next cycle then carries one rpt_valid pulse with rpt_col equal to that column index.
- R6: rpt_over bit r is set when both detects of row r were seen during the column.
- R7: If the ramp code has been at its maximum (255) for a full step and rows are still unruptured, the column ends anyway and those rows are set in rpt_under.
- R8: A read command (cmd_op = 0) drives rd_row_sel one-hot at cmd_row for SENSE_CYCLES cycles. It then gives one rsp_valid pulse with rsp_row = cmd_row and rsp_data bit c = 1 when only the right device conducts, 0 when only the left does.
- R9: rsp_err bit c is set when column c shows both or neither device conducting. A column that nothing drives reads as data 0.
- R10: A lock_set pulse sets locked. It then stays set until rst_n, whatever commands follow.
- R11: A program command accepted while locked gives a one-cycle prog_err pulse in the next cycle. It leaves busy low and produces no ramp_en or col_sel activity.
- R12: Commands presented while busy are ignored, and rsp_valid never appears during a program run. busy falls in the same cycle as rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 1 | 0 = read one row, 1 = program array |
| cmd_row | input | ROW_W | Row to read |
| lock_set | input | 1 | Sets the permanent program lock |
| step_cycles | input | STEP_W | Cycles per ramp step (0 acts as 1) |
| busy | output | 1 | Command in progress |
| locked | output | 1 | Program lock state |
| prog_err | output | 1 | Program refused because locked |
| ramp_en | output | 1 | Sweep generator enable |
| ramp_code | output | CODE_W | Sweep level code |
| col_sel | output | COLS | One-hot program column select |
| row_drive | output | ROWS | Per-row supply enable during programming |
| blow_left | input | ROWS | Left device ruptured, per row, on selected column |
| blow_right | input | ROWS | Right device ruptured, per row, on selected column |
| rpt_valid | output | 1 | Column report strobe |
| rpt_col | output | COL_W | Reported column |
| rpt_over | output | ROWS | Rows with both devices ruptured |
| rpt_under | output | ROWS | Rows with no device ruptured |
| rd_row_sel | output | ROWS | One-hot read row select |
| sense_left | input | COLS | Left device conducts, per column |
| sense_right | input | COLS | Right device conducts, per column |
| rsp_valid | output | 1 | Read response strobe |
| rsp_row | output | ROW_W | Row of the response |
| rsp_data | output | COLS | Response bits |
| rsp_err | output | COLS | Per-column validity error |

## Verification
Some properties hold on every cycle, and the assertions check them there. The column and read selects are one-hot and never overlap. The ramp code only holds, rises by one or clears. A row whose detect fired stays undriven while its column lasts. The lock never falls, and an idle locked block starts no sweep. Reports follow in column order, and responses coincide with idle. Other behaviours need the bench's scenarios against a modelled array of per-cell rupture thresholds and secret bits. These are the exact step spacing for a given step setting (including zero), early column completion, and the contents of the over and under masks. The same holds for the bits read back after programming and the refusal of program commands once locked.

// File: rtl/puf_pkg.sv
package puf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PROG = 2'd1,
    ST_READ = 2'd2
  } puf_state_e;

  localparam logic OP_READ = 1'b0;
  localparam logic OP_PROG = 1'b1;
endpackage

// File: rtl/puf_step_timer.sv
// Divides the clock into ramp steps; tick marks the last cycle of a step.
module puf_step_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_n, last_val;

  always_comb begin
    last_val = (period == '0) ? '0 : period - 1'b1;
    tick     = run && (cnt_q == last_val);
    if (!run || restart || tick) cnt_n = '0;
    else                         cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // R3: counter never runs past the step length while the setting holds
  a_r3_cnt_in_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(period)) |-> (cnt_q <= last_val));
endmodule

// File: rtl/puf_ramp_gen.sv
// Sweep level code: clears, holds or rises by one, saturating at maximum.
module puf_ramp_gen #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic [CODE_W-1:0] code,
  output logic              at_max
);
  logic [CODE_W-1:0] code_q, code_n;

  always_comb begin
    at_max = &code_q;
    if (clear)                code_n = '0;
    else if (step && !at_max) code_n = code_q + 1'b1;
    else                      code_n = code_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_n;
  end

  assign code = code_q;

  // R3: without a clear the level only holds or rises by one
  a_r3_unit_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((code == $past(code)) || (code == $past(code) + 1'b1)));
endmodule

// File: rtl/puf_col_tracker.sv
// Per-row rupture tracking for the column being programmed.
module puf_col_tracker #(
  parameter int ROWS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            finish,
  input  logic [ROWS-1:0] blow_l,
  input  logic [ROWS-1:0] blow_r,
  output logic [ROWS-1:0] drive,
  output logic [ROWS-1:0] upd_l,
  output logic [ROWS-1:0] upd_r,
  output logic            all_done
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic seen_l_q, seen_r_q, seen_l_n, seen_r_n;

    assign upd_l[r]  = seen_l_q | (active & blow_l[r]);
    assign upd_r[r]  = seen_r_q | (active & blow_r[r]);
    assign seen_l_n  = (active && !finish) ? upd_l[r] : 1'b0;
    assign seen_r_n  = (active && !finish) ? upd_r[r] : 1'b0;
    assign drive[r]  = active & ~(seen_l_q | seen_r_q);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seen_l_q <= 1'b0;
        seen_r_q <= 1'b0;
      end else begin
        seen_l_q <= seen_l_n;
        seen_r_q <= seen_r_n;
      end
    end

    // R4: a detect on this row withdraws its supply for the rest of the column
    a_r4_row_released: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && !$past(finish) && $past(blow_l[r] | blow_r[r]))
        |-> !drive[r]);
  end

  assign all_done = &(upd_l | upd_r);
endmodule

// File: rtl/puf_row_sense.sv
// Row-parallel read: selects one row, waits for sensing, captures the word.
module puf_row_sense #(
  parameter int ROWS         = 16,
  parameter int COLS         = 16,
  parameter int SENSE_CYCLES = 2,
  parameter int ROW_W        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [ROW_W-1:0] row_idx,
  input  logic [COLS-1:0]  sense_l,
  input  logic [COLS-1:0]  sense_r,
  output logic [ROWS-1:0]  row_sel,
  output logic             last,
  output logic             rsp_valid,
  output logic [ROW_W-1:0] rsp_row,
  output logic [COLS-1:0]  rsp_data,
  output logic [COLS-1:0]  rsp_err
);
  localparam int SC_W = $clog2(SENSE_CYCLES + 1);

  logic [SC_W-1:0] cnt_q, cnt_n;

  for (genvar i = 0; i < ROWS; i++) begin : g_sel
    assign row_sel[i] = active && (row_idx == ROW_W'(i));
  end

  always_comb begin
    last  = active && (cnt_q == SC_W'(SENSE_CYCLES - 1));
    cnt_n = (!active || last) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      rsp_valid <= 1'b0;
      rsp_row   <= '0;
      rsp_data  <= '0;
      rsp_err   <= '0;
    end else begin
      cnt_q     <= cnt_n;
      rsp_valid <= last;
      if (last) begin
        rsp_row  <= row_idx;
        rsp_data <= sense_r;
        rsp_err  <= ~(sense_l ^ sense_r);
      end
    end
  end

  // R8: at most one row is ever selected for sensing
  a_r8_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_sel));
  // R8: one response pulse per read
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/puf_array_ctrl.sv
module puf_array_ctrl #(
  parameter int ROWS         = 16,
  parameter int COLS         = 16,
  parameter int CODE_W       = 8,
  parameter int STEP_W       = 8,
  parameter int SENSE_CYCLES = 2,
  localparam int ROW_W       = $clog2(ROWS),
  localparam int COL_W       = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_op,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic              lock_set,
  input  logic [STEP_W-1:0] step_cycles,
  output logic              busy,
  output logic              locked,
  output logic              prog_err,
  output logic              ramp_en,
  output logic [CODE_W-1:0] ramp_code,
  output logic [COLS-1:0]   col_sel,
  output logic [ROWS-1:0]   row_drive,
  input  logic [ROWS-1:0]   blow_left,
  input  logic [ROWS-1:0]   blow_right,
  output logic              rpt_valid,
  output logic [COL_W-1:0]  rpt_col,
  output logic [ROWS-1:0]   rpt_over,
  output logic [ROWS-1:0]   rpt_under,
  output logic [ROWS-1:0]   rd_row_sel,
  input  logic [COLS-1:0]   sense_left,
  input  logic [COLS-1:0]   sense_right,
  output logic              rsp_valid,
  output logic [ROW_W-1:0]  rsp_row,
  output logic [COLS-1:0]   rsp_data,
  output logic [COLS-1:0]   rsp_err
);
  import puf_pkg::*;

  puf_state_e       state_q, state_n;
  logic [COL_W-1:0] col_q, col_n;
  logic [ROW_W-1:0] row_q, row_n;
  logic             locked_q, prog_err_q, rpt_valid_q;
  logic [COL_W-1:0] rpt_col_q;
  logic [ROWS-1:0]  rpt_over_q, rpt_under_q;
  logic             in_prog, in_read, accept, prog_go, prog_deny, read_go;
  logic             col_finish, tick, at_max, all_done, sense_last;
  logic             ramp_step, ramp_clear;
  logic [ROWS-1:0]  upd_l, upd_r;

  assign in_prog = (state_q == ST_PROG);
  assign in_read = (state_q == ST_READ);

  // Next-state logic
  always_comb begin
    accept     = cmd_valid && (state_q == ST_IDLE);
    prog_go    = accept && (cmd_op == OP_PROG) && !locked_q;
    prog_deny  = accept && (cmd_op == OP_PROG) && locked_q;
    read_go    = accept && (cmd_op == OP_READ);
    col_finish = in_prog && (all_done || (tick && at_max));
    ramp_step  = in_prog && tick && !col_finish;
    ramp_clear = !in_prog || col_finish;
    state_n    = state_q;
    col_n      = col_q;
    row_n      = row_q;
    unique case (state_q)
      ST_IDLE: begin
        if (prog_go) begin
          state_n = ST_PROG;
          col_n   = '0;
        end else if (read_go) begin
          state_n = ST_READ;
          row_n   = cmd_row;
        end
      end
      ST_PROG: begin
        if (col_finish) begin
          if (col_q == COL_W'(COLS - 1)) state_n = ST_IDLE;
          else                           col_n   = col_q + 1'b1;
        end
      end
      ST_READ: begin
        if (sense_last) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      col_q       <= '0;
      row_q       <= '0;
      locked_q    <= 1'b0;
      prog_err_q  <= 1'b0;
      rpt_valid_q <= 1'b0;
    end else begin
      state_q     <= state_n;
      col_q       <= col_n;
      row_q       <= row_n;
      locked_q    <= locked_q | lock_set;
      prog_err_q  <= prog_deny;
      rpt_valid_q <= col_finish;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_col_q   <= '0;
      rpt_over_q  <= '0;
      rpt_under_q <= '0;
    end else if (col_finish) begin
      rpt_col_q   <= col_q;
      rpt_over_q  <= upd_l & upd_r;
      rpt_under_q <= ~(upd_l | upd_r);
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_sel[c] = in_prog && (col_q == COL_W'(c));
  end

  puf_step_timer #(.CNT_W(STEP_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(in_prog), .restart(col_finish),
    .period(step_cycles), .tick(tick)
  );

  puf_ramp_gen #(.CODE_W(CODE_W)) u_ramp (
    .clk(clk), .rst_n(rst_n), .clear(ramp_clear), .step(ramp_step),
    .code(ramp_code), .at_max(at_max)
  );

  puf_col_tracker #(.ROWS(ROWS)) u_track (
    .clk(clk), .rst_n(rst_n), .active(in_prog), .finish(col_finish),
    .blow_l(blow_left), .blow_r(blow_right), .drive(row_drive),
    .upd_l(upd_l), .upd_r(upd_r), .all_done(all_done)
  );

  puf_row_sense #(.ROWS(ROWS), .COLS(COLS), .SENSE_CYCLES(SENSE_CYCLES), .ROW_W(ROW_W)) u_sense (
    .clk(clk), .rst_n(rst_n), .active(in_read), .row_idx(row_q),
    .sense_l(sense_left), .sense_r(sense_right), .row_sel(rd_row_sel),
    .last(sense_last), .rsp_valid(rsp_valid), .rsp_row(rsp_row),
    .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  assign busy      = (state_q != ST_IDLE);
  assign locked    = locked_q;
  assign prog_err  = prog_err_q;
  assign ramp_en   = in_prog;
  assign rpt_valid = rpt_valid_q;
  assign rpt_col   = rpt_col_q;
  assign rpt_over  = rpt_over_q;
  assign rpt_under = rpt_under_q;

  // R2: a single column at a time
  a_r2_col_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_sel));
  // R2: programming and reading never overlap
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !((|col_sel) && (|rd_row_sel)));
  // R5: after a report the sweep has moved to the next column
  a_r5_col_order: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_valid && busy) |-> (col_sel == (COLS'(1) << (rpt_col + 1'b1))));
  // R10: the lock never falls
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  // R11: an idle locked block starts no sweep
  a_r11_locked_no_ramp: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !busy) |=> !ramp_en);
  // R12: a response coincides with idle
  a_r12_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);
endmodule

// File: tb/puf_array_ctrl_bench.sv
`timescale 1ns/1ps
module puf_array_ctrl_bench;
  localparam int ROWS = 16;
  localparam int COLS = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_op = 1'b0;
  logic [3:0]  cmd_row = '0;
  logic        lock_set = 1'b0;
  logic [7:0]  step_cycles = '0;
  logic        busy, locked, prog_err, ramp_en, rpt_valid, rsp_valid;
  logic [7:0]  ramp_code;
  logic [15:0] col_sel, row_drive, rpt_over, rpt_under, rd_row_sel, rsp_data, rsp_err;
  logic [15:0] blow_left = '0, blow_right = '0, sense_left = '0, sense_right = '0;
  logic [3:0]  rpt_col, rsp_row;

  always #2.5 clk = ~clk;

  puf_array_ctrl u_puf_array_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_row(cmd_row), .lock_set(lock_set), .step_cycles(step_cycles),
    .busy(busy), .locked(locked), .prog_err(prog_err), .ramp_en(ramp_en),
    .ramp_code(ramp_code), .col_sel(col_sel), .row_drive(row_drive),
    .blow_left(blow_left), .blow_right(blow_right), .rpt_valid(rpt_valid),
    .rpt_col(rpt_col), .rpt_over(rpt_over), .rpt_under(rpt_under),
    .rd_row_sel(rd_row_sel), .sense_left(sense_left), .sense_right(sense_right),
    .rsp_valid(rsp_valid), .rsp_row(rsp_row), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Array model: per-cell rupture threshold, secret bit, and defect cells.
  function automatic bit is_double(input int r, input int c);
    return (r == 2 && c == 5) || (r == 9 && c == 11);
  endfunction
  function automatic bit is_never(input int r, input int c);
    return (r == 4 && c == 0) || (r == 15 && c == 15);
  endfunction
  function automatic int thr(input int r, input int c);
    return is_never(r, c) ? 1000 : 10 + ((r * 7 + c * 13) % 60);
  endfunction
  function automatic bit secret(input int r, input int c);
    return ((r * 5 + c * 3 + r * c) % 7) % 2 == 1;
  endfunction
  function automatic logic [15:0] over_mask(input int c);
    logic [15:0] m = '0;
    for (int r = 0; r < ROWS; r++) m[r] = is_double(r, c);
    return m;
  endfunction
  function automatic logic [15:0] under_mask(input int c);
    logic [15:0] m = '0;
    for (int r = 0; r < ROWS; r++) m[r] = is_never(r, c);
    return m;
  endfunction

  bit rup_l [ROWS][COLS];
  bit rup_r [ROWS][COLS];
  bit pend [ROWS];
  int pend_col [ROWS];

  always @(negedge clk) begin
    int c;
    int rr;
    c = -1;
    for (int i = 0; i < COLS; i++) if (col_sel[i]) c = i;
    for (int r = 0; r < ROWS; r++) begin
      if (pend[r]) begin
        if (ramp_en && c == pend_col[r])
          chk(row_drive[r] == 1'b0, "R4 row released after detect", row_drive[r], 0);
        pend[r] = 1'b0;
      end
    end
    if (ramp_en && c >= 0) begin
      for (int r = 0; r < ROWS; r++) begin
        if (row_drive[r] && !rup_l[r][c] && !rup_r[r][c] && int'(ramp_code) >= thr(r, c)) begin
          if (is_double(r, c)) begin
            rup_l[r][c] = 1'b1;
            rup_r[r][c] = 1'b1;
          end else if (secret(r, c)) rup_r[r][c] = 1'b1;
          else                       rup_l[r][c] = 1'b1;
          pend[r] = 1'b1;
          pend_col[r] = c;
        end
        blow_left[r]  = rup_l[r][c];
        blow_right[r] = rup_r[r][c];
      end
    end else begin
      blow_left  = '0;
      blow_right = '0;
    end
    rr = -1;
    for (int i = 0; i < ROWS; i++) if (rd_row_sel[i]) rr = i;
    for (int k = 0; k < COLS; k++) begin
      sense_left[k]  = (rr >= 0) ? rup_l[rr][k] : 1'b0;
      sense_right[k] = (rr >= 0) ? rup_r[rr][k] : 1'b0;
    end
  end

  // Ramp spacing, column reports and stray responses
  int   step_eff = 1;
  int   since = 0;
  int   last_code = 0;
  logic [15:0] last_col = '0;
  bit   was_en = 1'b0;
  int   exp_col = 0;
  int   rpt_count = 0;
  bit   in_prog_run = 1'b0;

  always @(negedge clk) begin
    if (ramp_en) begin
      if (!was_en || col_sel != last_col) begin
        chk(ramp_code == 8'd0, "R3 ramp starts at zero", ramp_code, 0);
        since = 1;
        last_code = int'(ramp_code);
      end else if (int'(ramp_code) == last_code) begin
        since++;
      end else begin
        chk(int'(ramp_code) == last_code + 1, "R3 ramp unit rise", ramp_code, last_code + 1);
        chk(since == step_eff, "R3 step spacing", since, step_eff);
        since = 1;
        last_code = int'(ramp_code);
      end
    end
    was_en = ramp_en;
    last_col = col_sel;
    if (rpt_valid) begin
      chk(int'(rpt_col) == exp_col, "R5 report column", rpt_col, exp_col);
      chk(rpt_over == over_mask(exp_col), "R6 over mask", rpt_over, over_mask(exp_col));
      chk(rpt_under == under_mask(exp_col), "R7 under mask", rpt_under, under_mask(exp_col));
      chk(busy == (exp_col != COLS - 1), "R2 busy through last report", busy, exp_col != COLS - 1);
      exp_col++;
      rpt_count++;
    end
    if (rsp_valid && in_prog_run)
      chk(1'b0, "R12 response during program run", 1, 0);
  end

  task automatic send_cmd(input logic op, input int row);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op = op;
    cmd_row = 4'(row);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic run_program(input int step, input bit poke_read);
    int n;
    step_cycles = 8'(step);
    step_eff = (step == 0) ? 1 : step;
    exp_col = 0;
    rpt_count = 0;
    in_prog_run = 1'b1;
    send_cmd(1'b1, 0);
    chk(busy == 1'b1, "R2 busy after program accept", busy, 1);
    chk(ramp_en == 1'b1 && col_sel == 16'h0001, "R2 first column selected", col_sel, 1);
    chk(row_drive == 16'hffff, "R4 all rows driven at column start", row_drive, 16'hffff);
    if (poke_read) begin
      repeat (40) @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op = 1'b0;
      cmd_row = 4'd3;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    n = 0;
    while (busy && n < 60000) begin
      @(negedge clk);
      n++;
    end
    repeat (5) @(negedge clk);
    in_prog_run = 1'b0;
    chk(rpt_count == COLS, "R5 one report per column", rpt_count, COLS);
    chk(busy == 1'b0 && ramp_en == 1'b0, "R12 idle after program", busy, 0);
  endtask

  task automatic do_read(input int r);
    int n;
    logic [15:0] ed, ee;
    ed = '0;
    ee = '0;
    for (int c = 0; c < COLS; c++) begin
      ed[c] = is_double(r, c) ? 1'b1 : (is_never(r, c) ? 1'b0 : secret(r, c));
      ee[c] = is_double(r, c) || is_never(r, c);
    end
    send_cmd(1'b0, r);
    chk(rd_row_sel == (16'd1 << r) && col_sel == '0, "R8 row select one-hot", rd_row_sel, 16'd1 << r);
    n = 0;
    while (!rsp_valid && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(rsp_valid == 1'b1, "R8 response arrives", rsp_valid, 1);
    chk(int'(rsp_row) == r, "R8 response row", rsp_row, r);
    chk(rsp_data == ed, "R8 response bits", rsp_data, ed);
    chk(rsp_err == ee, "R9 validity mask", rsp_err, ee);
    chk(busy == 1'b0, "R12 busy falls with response", busy, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      finish_run();
    end
  end

  task automatic check_reset_state(input string tag);
    chk(busy == 0 && locked == 0 && prog_err == 0 && ramp_en == 0, tag, {busy, locked, prog_err, ramp_en}, 0);
    chk(rpt_valid == 0 && rsp_valid == 0, tag, {rpt_valid, rsp_valid}, 0);
    chk(col_sel == 0 && row_drive == 0 && rd_row_sel == 0, tag, col_sel | row_drive | rd_row_sel, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check_reset_state("R1 state after reset release");

    run_program(2, 1'b1);
    for (int r = 0; r < ROWS; r++) do_read(r);

    chk(locked == 1'b0, "R10 unlocked before lock", locked, 0);
    @(negedge clk);
    lock_set = 1'b1;
    @(negedge clk);
    lock_set = 1'b0;
    chk(locked == 1'b1, "R10 lock set", locked, 1);
    for (int t = 0; t < 2; t++) begin
      send_cmd(1'b1, 0);
      chk(prog_err == 1'b1, "R11 refusal pulse", prog_err, 1);
      chk(busy == 1'b0 && ramp_en == 1'b0 && col_sel == '0, "R11 no sweep when locked", {busy, ramp_en}, 0);
      @(negedge clk);
      chk(prog_err == 1'b0, "R11 refusal is one cycle", prog_err, 0);
      repeat (10) @(negedge clk);
      chk(ramp_en == 1'b0 && row_drive == '0, "R11 still no drive", row_drive, 0);
      chk(locked == 1'b1, "R10 lock survives commands", locked, 1);
    end
    do_read(5);
    chk(locked == 1'b1, "R10 lock survives read", locked, 1);

    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state("R1 power-up clears lock");
    rst_n = 1'b1;
    @(negedge clk);
    run_program(0, 1'b0);
    do_read(9);
    finish_run();
  end
endmodule